// File: doc/BRIEF.md
# Multiplexed-Bus Static Word Memory with Chain Enable

This block stores 64 words of 8 bits for a processor that puts the high and low halves of an address on the same pins, one after the other. While the address strobe is pulsed, the block captures the level of its combined select/A5 pin on the strobe's falling edge. That captured level then acts as one chip-select term, so no external latch or decoder is needed. If the strobe is held high, the capture is bypassed and the same pin serves only as address bit 5.

Two further select inputs qualify the device: `cs1` must be 1 and `cs2` must be 0. Reads and writes use active-low strobes, and a write wins when both are low, so a single read/write line can drive the pair. The bidirectional bus is split into `din`, `dout` and `doe`. The chain-enable output lets a second device sit behind this one. That output stays high while this memory is selected and drops only during a read that this memory does not claim.

All inputs are sampled on the rising edge of `clk`. Writes commit on that edge. Read data, the bus enable and the chain enable are combinational from the current inputs and the capture register.

Top module: `mux_sel_ram`

## Requirements
- R1: The memory holds 64 words of 8 bits. The word address is {`sel_a5`, `addr_lo`[4:0]}, with `sel_a5` as bit 5, and a word written there is read back unchanged.
- R2: On a rising clock edge where `astb` is sampled low and was sampled high at the previous edge, the capture register loads `sel_a5`. At every other edge it holds its value.
- R3: While `astb` is high, the select qualifier is 1 and `sel_a5` acts only as address bit 5.
- R4: The device is selected only when the qualifier is 1, `cs1` is 1 and `cs2` is 0. When it is not selected, a write leaves memory unchanged and `doe` is 0.
- R5: When `wr_n` and `rd_n` are both 0 on a selected device, the write commits at the clock edge and `doe` stays 0.
- R6: `doe` is 1 exactly when the device is selected, `rd_n` is 0 and `wr_n` is 1. While `doe` is 0, `dout` is all zeros.
- R7: `chain_en` equals (selected OR `rd_n`), so it is 0 only during a read while the device is deselected.
- R8: During a read, `dout` follows a change of address within the same cycle, with no clock edge needed.
- R9: Reset clears the capture register to 0 and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the capture register |
| addr_lo | input | 5 | Word address bits 4..0 |
| sel_a5 | input | 1 | Combined select/address-bit-5 pin |
| astb | input | 1 | Address strobe; its falling edge captures `sel_a5` |
| cs1 | input | 1 | Select input, active high |
| cs2 | input | 1 | Select input, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; overrides the read strobe |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus; zero when not driving |
| doe | output | 1 | Bus output enable |
| chain_en | output | 1 | Chain enable for the next device in the daisy chain |

## Verification
The assertions assume that every input changes only between rising clock edges and is stable at each edge. They also assume that the strobe history used for edge detection begins at the first edge after reset. The checker therefore ignores that first edge, because before it there is no sampled strobe value to compare against. The bench drives all inputs on the falling clock edge and keeps `astb` low through reset. Strobe pulses last at least one full cycle, so every pulse is seen high at one edge and low at the next.

// File: rtl/mux_sel_ram_pkg.sv
package mux_sel_ram_pkg;

   localparam int unsigned LO_ADDR_W_DEF = 5;
   localparam int unsigned DATA_W_DEF    = 8;

   typedef struct packed {
      logic rd_n;
      logic wr_n;
   } strobe_t;

   function automatic logic strobe_reading(input strobe_t s);
      return (!s.rd_n) && s.wr_n;
   endfunction

   function automatic logic strobe_writing(input strobe_t s);
      return !s.wr_n;
   endfunction

endpackage

// File: rtl/mux_sel_ram_capture.sv
module mux_sel_ram_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic pin,
   output logic qual,
   output logic cap
);

   logic strobe_q;
   logic cap_q;
   logic fall;

   assign fall = strobe_q && !strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         cap_q    <= 1'b0;
      end else begin
         strobe_q <= strobe;
         if (fall) begin
            cap_q <= pin;
         end
      end
   end

   assign qual = strobe ? 1'b1 : cap_q;
   assign cap  = cap_q;

endmodule

// File: rtl/mux_sel_ram_ctrl.sv
module mux_sel_ram_ctrl
   import mux_sel_ram_pkg::*;
(
   input  logic    qual,
   input  logic    cs1,
   input  logic    cs2,
   input  strobe_t stb,
   output logic    sel,
   output logic    we,
   output logic    oe,
   output logic    chain
);

   assign sel   = qual && cs1 && !cs2;
   assign we    = sel && strobe_writing(stb);
   assign oe    = sel && strobe_reading(stb);
   assign chain = sel || stb.rd_n;

endmodule

// File: rtl/mux_sel_ram_array.sv
module mux_sel_ram_array #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned FLAT_W = DEPTH * DATA_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("mux_sel_ram_array: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mux_sel_ram_array: DATA_W must be positive");
      end
   endgenerate

   logic [FLAT_W-1:0] flat;

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_word
         logic [DATA_W-1:0] word_q;
         logic              hit;
         assign hit = we && (addr == ADDR_W'(gi));
         always_ff @(posedge clk) begin
            if (hit) begin
               word_q <= wdata;
            end
         end
         assign flat[gi*DATA_W +: DATA_W] = word_q;
      end
   endgenerate

   assign rdata = flat[addr*DATA_W +: DATA_W];

endmodule

// File: rtl/mux_sel_ram.sv
module mux_sel_ram
   import mux_sel_ram_pkg::*;
#(
   parameter int unsigned LO_ADDR_W = LO_ADDR_W_DEF,
   parameter int unsigned DATA_W    = DATA_W_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LO_ADDR_W-1:0] addr_lo,
   input  logic                 sel_a5,
   input  logic                 astb,
   input  logic                 cs1,
   input  logic                 cs2,
   input  logic                 rd_n,
   input  logic                 wr_n,
   input  logic [DATA_W-1:0]    din,
   output logic [DATA_W-1:0]    dout,
   output logic                 doe,
   output logic                 chain_en
);

   localparam int unsigned ADDR_W = LO_ADDR_W + 1;

   generate
      if (LO_ADDR_W < 1) begin : g_bad_lo
         $error("mux_sel_ram: LO_ADDR_W must be positive");
      end
   endgenerate

   logic              qual;
   logic              sel_cap;
   logic              sel;
   logic              we;
   logic              oe;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] rdata;
   strobe_t           stb;

   assign addr     = {sel_a5, addr_lo};
   assign stb.rd_n = rd_n;
   assign stb.wr_n = wr_n;

   mux_sel_ram_capture u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (astb),
      .pin    (sel_a5),
      .qual   (qual),
      .cap    (sel_cap)
   );

   mux_sel_ram_ctrl u_ctrl (
      .qual  (qual),
      .cs1   (cs1),
      .cs2   (cs2),
      .stb   (stb),
      .sel   (sel),
      .we    (we),
      .oe    (oe),
      .chain (chain_en)
   );

   mux_sel_ram_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_mem (
      .clk   (clk),
      .we    (we),
      .addr  (addr),
      .wdata (din),
      .rdata (rdata)
   );

   assign doe  = oe;
   assign dout = oe ? rdata : '0;

   logic unused_sel;
   assign unused_sel = sel;

endmodule

// File: rtl/mux_sel_ram_chk.sv
module mux_sel_ram_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_a5,
   input logic              astb,
   input logic              cs1,
   input logic              cs2,
   input logic              rd_n,
   input logic              wr_n,
   input logic [DATA_W-1:0] dout,
   input logic              doe,
   input logic              chain_en,
   input logic              sel_cap
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R6: bus enable only on a read with both selects valid
   p_oe_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      doe |-> (!rd_n && wr_n && cs1 && !cs2));

   // R6: idle bus carries zeros
   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !doe |-> (dout == '0));

   // R5: active write strobe keeps the bus off
   p_wr_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !doe);

   // R7: chain enable low only during an unclaimed read
   p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_en |-> (!rd_n && !doe));

   // R4: an invalid select never drives the bus
   p_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1 || cs2) |-> (!doe && (chain_en == rd_n)));

   // R2: strobe fall captures the pin
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $fell(astb) |=> (sel_cap == $past(sel_a5)));

   // R2: no fall, no change
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$fell(astb) |=> $stable(sel_cap));

endmodule

bind mux_sel_ram mux_sel_ram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_a5   (sel_a5),
   .astb     (astb),
   .cs1      (cs1),
   .cs2      (cs2),
   .rd_n     (rd_n),
   .wr_n     (wr_n),
   .dout     (dout),
   .doe      (doe),
   .chain_en (chain_en),
   .sel_cap  (sel_cap)
);

// File: tb/mux_sel_ram_tb_top.sv
module mux_sel_ram_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] addr_lo = '0;
   logic       sel_a5 = 1'b0;
   logic       astb = 1'b0;
   logic       cs1 = 1'b1;
   logic       cs2 = 1'b0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic       doe;
   logic       chain_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_sel_ram dut_i (
      .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .sel_a5(sel_a5),
      .astb(astb), .cs1(cs1), .cs2(cs2), .rd_n(rd_n), .wr_n(wr_n),
      .din(din), .dout(dout), .doe(doe), .chain_en(chain_en)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 5) ^ 8'h5A);
   endfunction

   task automatic write_word(input int a, input logic [7:0] d);
      @(negedge clk);
      {sel_a5, addr_lo} = 6'(a);
      din = d; wr_n = 1'b0; rd_n = 1'b1;
      @(negedge clk);
      wr_n = 1'b1;
   endtask

   task automatic read_check(input string tag, input int a, input logic [7:0] exp);
      @(negedge clk);
      {sel_a5, addr_lo} = 6'(a);
      rd_n = 1'b0; wr_n = 1'b1;
      #1;
      check({tag, " doe"}, int'(doe), 1);
      check({tag, " dout"}, int'(dout), int'(exp));
      rd_n = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rd_n = 1'b0;
      #1;
      check("R9 latch cleared doe", int'(doe), 0);
      check("R7 deselected read chain", int'(chain_en), 0);
      check("R6 idle dout", int'(dout), 0);
      rd_n = 1'b1;
      #1;
      check("R7 chain idle", int'(chain_en), 1);
   endtask

   task automatic t_fill;
      @(negedge clk); astb = 1'b1;
      for (int a = 0; a < 64; a++) write_word(a, pat(a));
      // R8: address changes every cycle while read stays low
      @(negedge clk); rd_n = 1'b0; wr_n = 1'b1;
      for (int a = 0; a < 64; a++) begin
         {sel_a5, addr_lo} = 6'(a);
         #1;
         check("R1 R3 R8 readback", int'(dout), int'(pat(a)));
         @(negedge clk);
      end
      rd_n = 1'b1;
   endtask

   task automatic t_selects;
      write_word(5, 8'hA1);
      @(negedge clk); cs2 = 1'b1;
      write_word(5, 8'h33);
      @(negedge clk); rd_n = 1'b0; #1;
      check("R4 cs2 high no doe", int'(doe), 0);
      check("R7 cs2 high chain", int'(chain_en), 0);
      rd_n = 1'b1;
      cs2 = 1'b0; cs1 = 1'b0;
      write_word(5, 8'h44);
      @(negedge clk); cs1 = 1'b1;
      read_check("R4 deselected write ignored", 5, 8'hA1);
   endtask

   task automatic t_priority;
      @(negedge clk);
      {sel_a5, addr_lo} = 6'd40;
      din = 8'hC7; wr_n = 1'b0; rd_n = 1'b0;
      #1;
      check("R5 both low no doe", int'(doe), 0);
      check("R7 selected chain", int'(chain_en), 1);
      @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
      read_check("R5 write committed", 40, 8'hC7);
   endtask

   task automatic t_mux;
      // capture 1, then low half addresses word 33 (A5 pin = 1)
      @(negedge clk); astb = 1'b1; sel_a5 = 1'b1; addr_lo = 5'd1;
      @(negedge clk); astb = 1'b0;
      @(negedge clk);
      write_word(33, 8'h9E);
      read_check("R2 captured high selects", 33, 8'h9E);
      read_check("R2 pin low addresses word 2", 2, pat(2));
      // capture 0
      @(negedge clk); astb = 1'b1; sel_a5 = 1'b0;
      @(negedge clk); astb = 1'b0;
      @(negedge clk); sel_a5 = 1'b1; rd_n = 1'b0; #1;
      check("R2 captured low deselects", int'(doe), 0);
      check("R7 captured low chain", int'(chain_en), 0);
      rd_n = 1'b1;
      write_word(34, 8'h11);
      // recapture 1; pin toggling while strobe low is ignored
      @(negedge clk); astb = 1'b1; sel_a5 = 1'b1;
      @(negedge clk); astb = 1'b0;
      @(negedge clk); sel_a5 = 1'b0;
      @(negedge clk);
      read_check("R2 hold after pin change", 3, pat(3));
      read_check("R4 write while captured low ignored", 34, pat(34));
   endtask

   task automatic t_reset_keep;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); rd_n = 1'b0; {sel_a5, addr_lo} = 6'd33; #1;
      check("R9 reset clears capture", int'(doe), 0);
      rd_n = 1'b1;
      @(negedge clk); astb = 1'b1;
      read_check("R9 memory kept", 33, 8'h9E);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_selects();
      t_priority();
      t_mux();
      t_reset_keep();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule